// File: doc/BRIEF.md
# Configurable Pad Cell Bank with Open-Drain Drive

This block models a row of general-purpose pad cells of a programmable logic fabric. Each cell takes a data bit from the logic array, a per-cell enable produced by a product term, and a small set of chip-wide enable pins. Static configuration bits set each cell's role:

- input only, output only, or bidirectional with a tri-state enable;
- which enable source governs the bidirectional case;
- whether the driver is push-pull or open-drain.

The pad itself is shown as a drive value plus a drive enable. The level seen on the pad is returned to the fabric in every role.

In open-drain drive a cell can only pull its pad low. A high data bit releases the pad, and an external pull-up sets the level. Several such cells on one shared wire form a wired-AND bus. Since each cell also reads its own pad back, logic in the fabric can sense whether any other agent is holding the line low. All pad-side outputs and the returned input are registered on the fabric clock, and a synchronous active-high reset clears them.

Top module: `pio_bank`

## Requirements
- R1: One clock edge after reset is asserted, every pad_oe, pad_out and fab_in bit is 0.
- R2: With role code 1 (output only) and push-pull drive, pad_oe is 1 and pad_out equals cell_data, one clock after the inputs are applied.
- R3: With role code 0 (input only) or the reserved role code 3, pad_oe is 0 whatever cell_data, cell_pt_oe and goe do.
- R4: With role code 2 (bidirectional), the cell's enable follows its source-select code: 0 picks cell_pt_oe, 1 picks goe[0], 2 picks goe[1], and 3 means always enabled. The result appears on pad_oe one clock later.
- R5: When a cell's cfg_pushpull bit is 0 (open-drain), pad_out is always 0, and pad_oe equals the role/source enable AND NOT cell_data.
- R6: When cfg_pushpull is 1 (the erased default), an enabled cell actively drives both levels: pad_oe is 1 and pad_out follows cell_data, high included.
- R7: fab_in returns the pad level one clock after it is sampled. This holds in every role, so a driving cell reads back its own pad.
- R8: Open-drain cells sharing one pulled-up wire read the wire as 0 when any enabled cell has data 0, and as 1 when all enabled cells have data 1 or no cell is enabled. A cell in input-only role never pulls the wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_data | input | NUM_CELLS | Data from the logic array, one bit per cell |
| cell_pt_oe | input | NUM_CELLS | Product-term enable, one bit per cell |
| goe | input | NUM_GOE | Chip-wide enable pins, active high |
| cfg_role | input | 2*NUM_CELLS | Role code per cell: 0 input, 1 output, 2 bidirectional, 3 reserved (input) |
| cfg_oesel | input | SEL_W*NUM_CELLS | Enable source code per cell |
| cfg_pushpull | input | NUM_CELLS | Drive type per cell: 1 push-pull, 0 open-drain |
| pad_in | input | NUM_CELLS | Level present on each pad |
| pad_out | output | NUM_CELLS | Registered drive value per pad |
| pad_oe | output | NUM_CELLS | Registered drive enable per pad |
| fab_in | output | NUM_CELLS | Registered pad level returned to the fabric |

## Verification
pad_out and pad_oe are due on the first clock edge after cell_data, the enables or the configuration change. fab_in is due on the first edge after the pad level changes, so a data change reaches fab_in through the shared wire two edges later. The bench changes inputs only on falling edges. Its reference model updates on each rising edge from the levels held at that edge, and compares on the next falling edge. The directed wired-AND checks wait two full cycles before they read fab_in.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    PIO_ROLE_IN    = 2'd0,
    PIO_ROLE_OUT   = 2'd1,
    PIO_ROLE_BIDIR = 2'd2,
    PIO_ROLE_RSVD  = 2'd3
  } pio_role_e;

  localparam int unsigned PIO_ROLE_W = 2;

  function automatic int unsigned pio_sel_width(input int unsigned num_goe);
    return $clog2(num_goe + 2);
  endfunction

endpackage

// File: rtl/pio_oe_select.sv
module pio_oe_select #(
  parameter int unsigned NUM_GOE = 2,
  localparam int unsigned SEL_W = pio_pkg::pio_sel_width(NUM_GOE)
) (
  input  logic [SEL_W-1:0]   oesel,
  input  logic               pt_oe,
  input  logic [NUM_GOE-1:0] goe,
  output logic               en_sel
);

  // code 0: product term, codes 1..NUM_GOE: global pins, above: always on
  always_comb begin
    en_sel = 1'b1;
    if (oesel == '0) begin
      en_sel = pt_oe;
    end else begin
      for (int unsigned k = 0; k < NUM_GOE; k++) begin
        if (oesel == SEL_W'(k + 1)) en_sel = goe[k];
      end
    end
  end

endmodule

// File: rtl/pio_drive.sv
module pio_drive
  import pio_pkg::*;
(
  input  pio_role_e role,
  input  logic      en_sel,
  input  logic      pushpull,
  input  logic      data,
  output logic      drv_oe,
  output logic      drv_val
);

  logic role_en;

  always_comb begin
    unique case (role)
      PIO_ROLE_OUT:   role_en = 1'b1;
      PIO_ROLE_BIDIR: role_en = en_sel;
      default:        role_en = 1'b0;
    endcase
  end

  always_comb begin
    if (pushpull) begin
      drv_oe  = role_en;
      drv_val = data;
    end else begin
      drv_oe  = role_en & ~data;
      drv_val = 1'b0;
    end
  end

endmodule

// File: rtl/pio_cell.sv
module pio_cell
  import pio_pkg::*;
#(
  parameter int unsigned NUM_GOE = 2,
  localparam int unsigned SEL_W = pio_sel_width(NUM_GOE)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               data,
  input  logic               pt_oe,
  input  logic [NUM_GOE-1:0] goe,
  input  pio_role_e          role,
  input  logic [SEL_W-1:0]   oesel,
  input  logic               pushpull,
  input  logic               pad_in,
  output logic               pad_out,
  output logic               pad_oe,
  output logic               fab_in
);

  logic en_sel;
  logic drv_oe;
  logic drv_val;

  pio_oe_select #(.NUM_GOE(NUM_GOE)) u_sel (
    .oesel  (oesel),
    .pt_oe  (pt_oe),
    .goe    (goe),
    .en_sel (en_sel)
  );

  pio_drive u_drv (
    .role     (role),
    .en_sel   (en_sel),
    .pushpull (pushpull),
    .data     (data),
    .drv_oe   (drv_oe),
    .drv_val  (drv_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
      fab_in  <= 1'b0;
    end else begin
      pad_out <= drv_val;
      pad_oe  <= drv_oe;
      fab_in  <= pad_in;
    end
  end

endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 4,
  parameter int unsigned NUM_GOE   = 2,
  localparam int unsigned SEL_W = pio_sel_width(NUM_GOE)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CELLS-1:0]         cell_data,
  input  logic [NUM_CELLS-1:0]         cell_pt_oe,
  input  logic [NUM_GOE-1:0]           goe,
  input  logic [PIO_ROLE_W*NUM_CELLS-1:0] cfg_role,
  input  logic [SEL_W*NUM_CELLS-1:0]   cfg_oesel,
  input  logic [NUM_CELLS-1:0]         cfg_pushpull,
  input  logic [NUM_CELLS-1:0]         pad_in,
  output logic [NUM_CELLS-1:0]         pad_out,
  output logic [NUM_CELLS-1:0]         pad_oe,
  output logic [NUM_CELLS-1:0]         fab_in
);

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    pio_cell #(.NUM_GOE(NUM_GOE)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .data     (cell_data[c]),
      .pt_oe    (cell_pt_oe[c]),
      .goe      (goe),
      .role     (pio_role_e'(cfg_role[c*PIO_ROLE_W +: PIO_ROLE_W])),
      .oesel    (cfg_oesel[c*SEL_W +: SEL_W]),
      .pushpull (cfg_pushpull[c]),
      .pad_in   (pad_in[c]),
      .pad_out  (pad_out[c]),
      .pad_oe   (pad_oe[c]),
      .fab_in   (fab_in[c])
    );
  end

endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk
  import pio_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 4,
  parameter int unsigned NUM_GOE   = 2,
  localparam int unsigned SEL_W = pio_sel_width(NUM_GOE)
) (
  input logic                            clk,
  input logic                            rst,
  input logic [NUM_CELLS-1:0]            cell_data,
  input logic [NUM_CELLS-1:0]            cell_pt_oe,
  input logic [NUM_GOE-1:0]              goe,
  input logic [PIO_ROLE_W*NUM_CELLS-1:0] cfg_role,
  input logic [SEL_W*NUM_CELLS-1:0]      cfg_oesel,
  input logic [NUM_CELLS-1:0]            cfg_pushpull,
  input logic [NUM_CELLS-1:0]            pad_in,
  input logic [NUM_CELLS-1:0]            pad_out,
  input logic [NUM_CELLS-1:0]            pad_oe,
  input logic [NUM_CELLS-1:0]            fab_in
);

  logic seen_edge = 1'b0;
  logic run_prev  = 1'b0;

  always_ff @(posedge clk) begin
    seen_edge <= 1'b1;
    run_prev  <= !rst;
  end

  // R1: reset clears every registered output
  p_reset_clear_r1: assert property (@(posedge clk)
    seen_edge && $past(rst) |-> (pad_oe == '0 && pad_out == '0 && fab_in == '0));

  // R7: pad level returns one clock later
  p_readback_r7: assert property (@(posedge clk) disable iff (rst)
    run_prev |-> fab_in == $past(pad_in));

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_chk
    // R3: input-only and reserved roles never drive
    p_input_only_r3: assert property (@(posedge clk) disable iff (rst)
      run_prev && ($past(cfg_role[c*2 +: 2]) == 2'd0 || $past(cfg_role[c*2 +: 2]) == 2'd3)
      |-> !pad_oe[c]);

    // R5: open-drain never drives a high level
    p_od_low_only_r5: assert property (@(posedge clk) disable iff (rst)
      run_prev && !$past(cfg_pushpull[c]) |-> !pad_out[c]);

    // R5: open-drain releases the pad on high data
    p_od_release_r5: assert property (@(posedge clk) disable iff (rst)
      run_prev && !$past(cfg_pushpull[c]) && $past(cell_data[c]) |-> !pad_oe[c]);

    // R2: push-pull output-only role drives the data
    p_out_role_r2: assert property (@(posedge clk) disable iff (rst)
      run_prev && $past(cfg_role[c*2 +: 2]) == 2'd1 && $past(cfg_pushpull[c])
      |-> (pad_oe[c] && pad_out[c] == $past(cell_data[c])));
  end

endmodule

bind pio_bank pio_bank_chk #(.NUM_CELLS(NUM_CELLS), .NUM_GOE(NUM_GOE)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cell_data    (cell_data),
  .cell_pt_oe   (cell_pt_oe),
  .goe          (goe),
  .cfg_role     (cfg_role),
  .cfg_oesel    (cfg_oesel),
  .cfg_pushpull (cfg_pushpull),
  .pad_in       (pad_in),
  .pad_out      (pad_out),
  .pad_oe       (pad_oe),
  .fab_in       (fab_in)
);

// File: tb/pio_bank_tb.sv
`timescale 1ns/1ps
module pio_bank_tb;

  localparam int N = 4;
  localparam int G = 2;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  cell_data = '0;
  logic [N-1:0]  cell_pt_oe = '0;
  logic [G-1:0]  goe = '0;
  logic [2*N-1:0] cfg_role = '0;
  logic [SW*N-1:0] cfg_oesel = '0;
  logic [N-1:0]  cfg_pushpull = '1;
  logic [N-1:0]  pad_in;
  logic [N-1:0]  pad_out, pad_oe, fab_in;
  logic          shared = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // pad wire model: each pad pulled up; shared mode ties all pads together
  logic [N-1:0] pull_low;
  assign pull_low = pad_oe & ~pad_out;
  always_comb begin
    for (int i = 0; i < N; i++)
      pad_in[i] = shared ? ~(|pull_low) : ~pull_low[i];
  end

  pio_bank #(.NUM_CELLS(N), .NUM_GOE(G)) u_dut (
    .clk(clk), .rst(rst), .cell_data(cell_data), .cell_pt_oe(cell_pt_oe),
    .goe(goe), .cfg_role(cfg_role), .cfg_oesel(cfg_oesel),
    .cfg_pushpull(cfg_pushpull), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .fab_in(fab_in)
  );

  // behavioural reference model
  bit exp_oe [N];
  bit exp_out[N];
  bit exp_fab[N];
  bit model_ok = 1'b0;

  always @(posedge clk) begin
    bit low_any;
    bit bus [N];
    low_any = 1'b0;
    for (int i = 0; i < N; i++) if (exp_oe[i] && !exp_out[i]) low_any = 1'b1;
    for (int i = 0; i < N; i++)
      bus[i] = shared ? !low_any : !(exp_oe[i] && !exp_out[i]);
    for (int i = 0; i < N; i++) begin
      int role, sel;
      bit en;
      role = int'(cfg_role[2*i +: 2]);
      sel  = int'(cfg_oesel[SW*i +: SW]);
      if (role == 1) en = 1'b1;
      else if (role == 2) begin
        if (sel == 0) en = cell_pt_oe[i];
        else if (sel == 1) en = goe[0];
        else if (sel == 2) en = goe[1];
        else en = 1'b1;
      end else en = 1'b0;
      if (rst) begin
        exp_oe[i] = 0; exp_out[i] = 0; exp_fab[i] = 0;
      end else begin
        exp_fab[i] = bus[i];
        if (cfg_pushpull[i]) begin exp_oe[i] = en; exp_out[i] = cell_data[i]; end
        else begin exp_oe[i] = en && !cell_data[i]; exp_out[i] = 1'b0; end
      end
    end
    model_ok = 1'b1;
  end

  function automatic string tag_for(int i);
    int role;
    role = int'(cfg_role[2*i +: 2]);
    if (role == 0 || role == 3) return "R3";
    if (!cfg_pushpull[i]) return "R5";
    if (role == 1) return "R2";
    return "R4";
  endfunction

  always @(negedge clk) begin
    if (model_ok && !done) begin
      for (int i = 0; i < N; i++) begin
        checks++;
        if (pad_oe[i] !== exp_oe[i] || pad_out[i] !== exp_out[i]) begin
          failures++;
          $display("FAIL %s cell %0d: oe/out actual=%b%b expected=%b%b",
                   tag_for(i), i, pad_oe[i], pad_out[i], exp_oe[i], exp_out[i]);
        end
        checks++;
        if (fab_in[i] !== exp_fab[i]) begin
          failures++;
          $display("FAIL R7 cell %0d: fab_in actual=%b expected=%b", i, fab_in[i], exp_fab[i]);
        end
      end
    end
  end

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic randomize_inputs();
    cell_data  = N'($urandom);
    cell_pt_oe = N'($urandom);
    goe        = G'($urandom);
  endtask

  initial begin
    cyc(2);
    // R1: reset state
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_out", pad_out, '0);
    check("R1 fab_in", fab_in, '0);
    rst = 1'b0;

    // R4: bidirectional, push-pull, each source code on its own cell
    cfg_role = {4{2'd2}};
    cfg_oesel = {2'd3, 2'd2, 2'd1, 2'd0};
    cfg_pushpull = '1;
    for (int k = 0; k < 40; k++) begin randomize_inputs(); cyc(1); end
    cell_pt_oe = 4'b0000; goe = 2'b10; cell_data = 4'b0101; cyc(1);
    check("R4 source select", pad_oe, 4'b1100);

    // R2 and R6: output-only push-pull drives both levels
    cfg_role = {4{2'd1}};
    cell_data = 4'b1111; cyc(1);
    check("R6 drive high oe", pad_oe, 4'b1111);
    check("R6 drive high out", pad_out, 4'b1111);
    cell_data = 4'b0110; cyc(1);
    check("R2 output data", pad_out, 4'b0110);
    for (int k = 0; k < 30; k++) begin randomize_inputs(); cyc(1); end

    // R3: input-only and reserved roles ignore every enable
    cfg_role = {2'd3, 2'd0, 2'd3, 2'd0};
    for (int k = 0; k < 30; k++) begin randomize_inputs(); cyc(1); end
    cell_pt_oe = '1; goe = '1; cell_data = '0; cyc(1);
    check("R3 no drive", pad_oe, '0);
    cyc(1);
    check("R3 pad released reads high", fab_in, '1);

    // mixed roles and drive types, random
    cfg_role = {2'd2, 2'd1, 2'd0, 2'd2};
    cfg_pushpull = 4'b0110;
    cfg_oesel = {2'd1, 2'd0, 2'd2, 2'd0};
    for (int k = 0; k < 40; k++) begin randomize_inputs(); cfg_oesel = (SW*N)'($urandom); cyc(1); end

    // R5 and R8: open-drain cells on one shared wire
    shared = 1'b1;
    cfg_role = {4{2'd2}};
    cfg_oesel = {4{2'd3}};
    cfg_pushpull = '0;
    cell_data = 4'b1111; cyc(2);
    check("R5 released", pad_oe, '0);
    check("R8 all high reads 1", fab_in, '1);
    cell_data = 4'b1011; cyc(1);
    check("R5 pull low only", pad_oe, 4'b0100);
    check("R5 value zero", pad_out, '0);
    cyc(1);
    check("R8 one low reads 0", fab_in, '0);
    cfg_role = {2'd2, 2'd0, 2'd2, 2'd2}; cyc(2);
    check("R8 input-only cell does not pull", fab_in, '1);
    cfg_oesel = {2'd0, 2'd0, 2'd0, 2'd0}; cell_pt_oe = 4'b0000; cell_data = '0; cyc(2);
    check("R8 disabled cells do not pull", fab_in, '1);
    for (int k = 0; k < 40; k++) begin randomize_inputs(); cyc(1); end

    // R1: reset in mid-run
    rst = 1'b1; cyc(1);
    check("R1 reset again oe", pad_oe, '0);
    check("R1 reset again fab", fab_in, '0);
    rst = 1'b0; cyc(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule